// File: doc/BRIEF.md
# Receive Address Filter for IEEE 802.15.4 Frames

This block watches the MAC header of an incoming IEEE 802.15.4 frame as the demodulator delivers it, one byte per accepted beat, and decides whether the frame is addressed to this node. It decodes the frame control field, works out from the addressing modes which header fields are present and where each one sits, and compares each field against the node's configured PAN identifier, short address and 64-bit extended address as the bytes go past.

The result is a one-cycle `match_o` pulse as soon as the last rule that applies is settled, or a one-cycle `reject_o` pulse at the first byte that breaks a rule. No further comparison is done once a rule has failed. The ack-request bit of the frame control field is captured from the first byte and held for the rest of the frame, so that an acknowledgement stage can use it after a match. Configuration inputs are expected to be stable while a frame is being received.

Top module: `rx_addr_filter`

## Requirements
- R1: `ack_req_o` is 0 after reset, takes bit 5 of the first frame byte (frame control bit 5) in the cycle after that byte, and holds it until the next start byte.
- R2: Frame type is frame control bits 2:0 (0 beacon, 1 data, 2 acknowledgement, 3 command); a type 2 frame is always rejected in the cycle after the second frame byte.
- R3: Types 4 to 7 are rejected after the second byte when `cfg_rsvd_as_data_i` is 0; when it is 1 they are filtered on their addresses exactly as data frames and can produce `match_o`.
- R4: Frame version is frame control bits 13:12 (bits 5:4 of the second byte); values 2 and 3 are rejected after the second byte, values 0 and 1 are accepted.
- R5: Destination addressing mode is frame control bits 11:10 and source mode bits 15:14 (0 absent, 2 16-bit, 3 64-bit); mode 1 in either, both modes 0, or PAN ID compression (bit 6) with no destination are rejected after the second byte.
- R6: Header layout: two frame control bytes (low first), one sequence byte, destination PAN (2), destination address (2 or 8), source PAN (2, omitted when compression is set), source address; multi-byte fields arrive least-significant byte first. A frame with a destination is judged on its destination alone unless it is a beacon.
- R7: A present destination PAN must equal `cfg_pan_id_i` or 0xFFFF.
- R8: A 16-bit destination address must equal `cfg_short_addr_i` or 0xFFFF; a 64-bit one must equal `cfg_ext_addr_i`.
- R9: For a beacon, the source PAN must equal `cfg_pan_id_i` unless that is 0xFFFF; when compression is set the destination PAN stands for it and must then equal `cfg_pan_id_i` exactly (broadcast not allowed).
- R10: A non-beacon frame with only source addressing is rejected after the second byte unless `cfg_pan_coord_i` is 1, and then needs its source PAN equal to `cfg_pan_id_i`.
- R11: `match_o` is asserted in the cycle after the last byte of the last field that is checked (after the second byte when no field is checked); `reject_o` in the cycle after the first byte at which a field can no longer equal any allowed value; cycles without `byte_vld_i` produce no pulse.
- R12: Each frame gives at most one single-cycle verdict, never both; bytes after the verdict are ignored, and a start byte restarts parsing even mid-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Marks the first byte of a frame, qualified by `byte_vld_i` |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Received byte |
| cfg_pan_id_i | input | PAN_W | Node PAN identifier |
| cfg_short_addr_i | input | SHORT_W | Node 16-bit address |
| cfg_ext_addr_i | input | EXT_W | Node 64-bit address |
| cfg_pan_coord_i | input | 1 | Node is PAN coordinator |
| cfg_rsvd_as_data_i | input | 1 | Filter reserved frame types as data frames |
| match_o | output | 1 | One-cycle pulse: frame is addressed to this node |
| reject_o | output | 1 | One-cycle pulse: frame is not for this node |
| ack_req_o | output | 1 | Ack-request bit of the current frame |

## Verification
Every verdict is registered once, so it is due exactly one clock after the byte that settles it: the second frame byte for frame-control rules, the deciding byte of a field for address rules, and nothing during idle beats. The bench feeds each frame to a behavioural model that yields the index of the deciding byte, drives bytes on the falling edge and compares all three outputs on every falling edge, including inserted idle beats, bytes past the verdict and a frame cut short by a new start. `ack_req_o` is expected from the cycle after the start byte.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FCH,
    ST_HDR,
    ST_DONE
  } flt_st_e;

  localparam logic [2:0] FT_BEACON = 3'd0;
  localparam logic [2:0] FT_ACK    = 3'd2;

  localparam logic [1:0] AM_NONE = 2'd0;
  localparam logic [1:0] AM_RSVD = 2'd1;
  localparam logic [1:0] AM_EXT  = 2'd3;

  localparam logic [7:0] BCAST_BYTE = 8'hFF;

  // fixed header offsets: two frame control bytes then sequence number
  localparam int SEQ_LEN = 3;

endpackage

// File: rtl/rx_addr_fcf_dec.sv
module rx_addr_fcf_dec
  import rx_addr_filter_pkg::*;
#(
  parameter int PAN_W   = 16,
  parameter int SHORT_W = 16,
  parameter int EXT_W   = 64,
  parameter int IDX_W   = 5
) (
  input  logic [2:0]       ftype_i,
  input  logic             comp_i,
  input  logic [1:0]       dmode_i,
  input  logic [1:0]       ver_i,
  input  logic [1:0]       smode_i,
  input  logic [PAN_W-1:0] cfg_pan_i,
  input  logic             pan_coord_i,
  input  logic             rsvd_pol_i,
  output logic             rej_o,
  output logic             dst_on_o,
  output logic             dst_ext_o,
  output logic             dpan_bc_o,
  output logic             span_on_o,
  output logic [IDX_W-1:0] dadr_last_o,
  output logic [IDX_W-1:0] span_off_o,
  output logic [IDX_W-1:0] last_idx_o
);

  localparam int PAN_B   = PAN_W / 8;
  localparam int SHORT_B = SHORT_W / 8;
  localparam int EXT_B   = EXT_W / 8;
  localparam logic [IDX_W-1:0] DADR_OFF   = IDX_W'(SEQ_LEN + PAN_B);
  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SEQ_LEN + PAN_B + SHORT_B - 1);
  localparam logic [IDX_W-1:0] EXT_LAST   = IDX_W'(SEQ_LEN + PAN_B + EXT_B - 1);
  localparam logic [IDX_W-1:0] SRC_PAN_NODST = IDX_W'(SEQ_LEN);

  logic is_beacon, is_rsvd, only_src, need_src;

  always_comb begin
    is_beacon = (ftype_i == FT_BEACON);
    is_rsvd   = ftype_i[2];
    dst_on_o  = (dmode_i != AM_NONE);
    dst_ext_o = (dmode_i == AM_EXT);
    only_src  = !dst_on_o && (smode_i != AM_NONE);

    rej_o = ver_i[1]
          || (ftype_i == FT_ACK)
          || (is_rsvd && !rsvd_pol_i)
          || (dmode_i == AM_RSVD) || (smode_i == AM_RSVD)
          || (!dst_on_o && (smode_i == AM_NONE))
          || (comp_i && !dst_on_o)
          || (only_src && !is_beacon && !pan_coord_i);

    need_src  = (is_beacon && (cfg_pan_i != {PAN_W{1'b1}})) || (only_src && !is_beacon);
    span_on_o = need_src && !comp_i;
    dpan_bc_o = !(need_src && comp_i);

    dadr_last_o = dst_ext_o ? EXT_LAST : SHORT_LAST;
    span_off_o  = dst_on_o ? dadr_last_o + IDX_W'(1) : SRC_PAN_NODST;

    if (span_on_o)     last_idx_o = span_off_o + IDX_W'(PAN_B - 1);
    else if (dst_on_o) last_idx_o = dadr_last_o;
    else               last_idx_o = IDX_W'(1);
  end

  initial begin
    if (DADR_OFF == '0) $error("bad header layout");
  end

endmodule

// File: rtl/rx_addr_fld_cmp.sv
module rx_addr_fld_cmp
  import rx_addr_filter_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       act_i,
  input  logic       first_i,
  input  logic [7:0] byte_i,
  input  logic [7:0] cand_i,
  input  logic       bc_en_i,
  output logic       fail_o
);

  logic alive_cfg_q, alive_bc_q;
  logic hit_cfg, hit_bc;

  // a candidate stays alive while every byte so far equals it
  always_comb begin
    hit_cfg = (first_i || alive_cfg_q) && (byte_i == cand_i);
    hit_bc  = bc_en_i && (first_i || alive_bc_q) && (byte_i == BCAST_BYTE);
    fail_o  = act_i && !hit_cfg && !hit_bc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alive_cfg_q <= 1'b0;
      alive_bc_q  <= 1'b0;
    end else if (act_i) begin
      alive_cfg_q <= hit_cfg;
      alive_bc_q  <= hit_bc;
    end
  end

  AST_BC_ONLY_WHEN_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i && !bc_en_i && byte_i != cand_i |-> fail_o); // R8

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
#(
  parameter int PAN_W   = 16,
  parameter int SHORT_W = 16,
  parameter int EXT_W   = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sof_i,
  input  logic               byte_vld_i,
  input  logic [7:0]         byte_i,
  input  logic [PAN_W-1:0]   cfg_pan_id_i,
  input  logic [SHORT_W-1:0] cfg_short_addr_i,
  input  logic [EXT_W-1:0]   cfg_ext_addr_i,
  input  logic               cfg_pan_coord_i,
  input  logic               cfg_rsvd_as_data_i,
  output logic               match_o,
  output logic               reject_o,
  output logic               ack_req_o
);

  localparam int PAN_B   = PAN_W / 8;
  localparam int EXT_B   = EXT_W / 8;
  localparam int HDR_MAX = SEQ_LEN + 2 * PAN_B + 2 * EXT_B;
  localparam int IDX_W   = $clog2(HDR_MAX + 1);
  localparam int KW      = $clog2(EXT_B);
  localparam logic [IDX_W-1:0] DPAN_OFF = IDX_W'(SEQ_LEN);
  localparam logic [IDX_W-1:0] DADR_OFF = IDX_W'(SEQ_LEN + PAN_B);

  flt_st_e          st_q;
  logic [IDX_W-1:0] idx_q;
  logic [3:0]       fcl_q;  // {pan id compression, frame type}

  logic             dst_on_q, dst_ext_q, dpan_bc_q, span_on_q;
  logic [IDX_W-1:0] dadr_last_q, span_off_q, last_idx_q;

  logic             dec_rej, dec_dst_on, dec_dst_ext, dec_dpan_bc, dec_span_on;
  logic [IDX_W-1:0] dec_dadr_last, dec_span_off, dec_last_idx;

  rx_addr_fcf_dec #(
    .PAN_W  (PAN_W),
    .SHORT_W(SHORT_W),
    .EXT_W  (EXT_W),
    .IDX_W  (IDX_W)
  ) u_dec (
    .ftype_i    (fcl_q[2:0]),
    .comp_i     (fcl_q[3]),
    .dmode_i    (byte_i[3:2]),
    .ver_i      (byte_i[5:4]),
    .smode_i    (byte_i[7:6]),
    .cfg_pan_i  (cfg_pan_id_i),
    .pan_coord_i(cfg_pan_coord_i),
    .rsvd_pol_i (cfg_rsvd_as_data_i),
    .rej_o      (dec_rej),
    .dst_on_o   (dec_dst_on),
    .dst_ext_o  (dec_dst_ext),
    .dpan_bc_o  (dec_dpan_bc),
    .span_on_o  (dec_span_on),
    .dadr_last_o(dec_dadr_last),
    .span_off_o (dec_span_off),
    .last_idx_o (dec_last_idx)
  );

  logic             hdr_step, in_dpan, in_dadr, in_span, fld_act, fld_first, fld_fail;
  logic [IDX_W-1:0] fld_base;
  logic [KW-1:0]    fld_k;
  logic [7:0]       cand_byte;
  logic             cand_bc;

  always_comb begin
    hdr_step = byte_vld_i && !sof_i && (st_q == ST_HDR);
    in_dpan  = dst_on_q && (idx_q >= DPAN_OFF) && (idx_q < DADR_OFF);
    in_dadr  = dst_on_q && (idx_q >= DADR_OFF) && (idx_q <= dadr_last_q);
    in_span  = span_on_q && (idx_q >= span_off_q) && (idx_q < span_off_q + IDX_W'(PAN_B));

    if (in_dpan)      fld_base = DPAN_OFF;
    else if (in_dadr) fld_base = DADR_OFF;
    else              fld_base = span_off_q;
    fld_k     = KW'(idx_q - fld_base);
    fld_first = (fld_k == '0);
    fld_act   = hdr_step && (in_dpan || in_dadr || in_span);

    if (in_dadr) begin
      cand_byte = dst_ext_q ? 8'(cfg_ext_addr_i >> (8 * fld_k))
                            : 8'(cfg_short_addr_i >> (8 * fld_k));
      cand_bc   = !dst_ext_q;
    end else begin
      cand_byte = 8'(cfg_pan_id_i >> (8 * fld_k));
      cand_bc   = in_dpan && dpan_bc_q;
    end
  end

  rx_addr_fld_cmp u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (fld_act),
    .first_i(fld_first),
    .byte_i (byte_i),
    .cand_i (cand_byte),
    .bc_en_i(cand_bc),
    .fail_o (fld_fail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      idx_q       <= '0;
      fcl_q       <= '0;
      ack_req_o   <= 1'b0;
      match_o     <= 1'b0;
      reject_o    <= 1'b0;
      dst_on_q    <= 1'b0;
      dst_ext_q   <= 1'b0;
      dpan_bc_q   <= 1'b0;
      span_on_q   <= 1'b0;
      dadr_last_q <= '0;
      span_off_q  <= '0;
      last_idx_q  <= '0;
    end else begin
      match_o  <= 1'b0;
      reject_o <= 1'b0;
      if (byte_vld_i) begin
        if (sof_i) begin
          st_q      <= ST_FCH;
          idx_q     <= IDX_W'(1);
          fcl_q     <= {byte_i[6], byte_i[2:0]};
          ack_req_o <= byte_i[5];
        end else begin
          unique case (st_q)
            ST_FCH: begin
              dst_on_q    <= dec_dst_on;
              dst_ext_q   <= dec_dst_ext;
              dpan_bc_q   <= dec_dpan_bc;
              span_on_q   <= dec_span_on;
              dadr_last_q <= dec_dadr_last;
              span_off_q  <= dec_span_off;
              last_idx_q  <= dec_last_idx;
              idx_q       <= idx_q + IDX_W'(1);
              if (dec_rej) begin
                reject_o <= 1'b1;
                st_q     <= ST_DONE;
              end else if (dec_last_idx == idx_q) begin
                match_o <= 1'b1;
                st_q    <= ST_DONE;
              end else begin
                st_q <= ST_HDR;
              end
            end
            ST_HDR: begin
              idx_q <= idx_q + IDX_W'(1);
              if (fld_fail) begin
                reject_o <= 1'b1;
                st_q     <= ST_DONE;
              end else if (idx_q == last_idx_q) begin
                match_o <= 1'b1;
                st_q    <= ST_DONE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_SINGLE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o || reject_o) |=> !(match_o || reject_o)); // R12
  AST_NOT_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(match_o && reject_o)); // R12
  AST_ACK_TYPE_REJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i && !sof_i && st_q == ST_FCH && fcl_q[2:0] == FT_ACK |=> reject_o); // R2
  AST_RSVD_VER_REJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i && !sof_i && st_q == ST_FCH && byte_i[5] |=> reject_o); // R4
  AST_ACK_REQ_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i && sof_i |=> ack_req_o == $past(byte_i[5])); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_i |=> !match_o && !reject_o); // R11

endmodule

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;

  typedef logic [7:0] bq_t[$];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0;
  logic        vld = 1'b0;
  logic [7:0]  bdat = 8'h00;
  logic [15:0] c_pan = 16'h1A2B;
  logic [15:0] c_short = 16'h0C0D;
  logic [63:0] c_ext = 64'h0123_4567_89AB_CDEF;
  logic        c_coord = 1'b0;
  logic        c_rsvd = 1'b0;
  logic        match, reject, ackr;

  int n_tests = 0;
  int n_fail  = 0;
  logic cur_ack = 1'b0;

  always #5 clk = ~clk;

  rx_addr_filter dut_i (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .sof_i             (sof),
    .byte_vld_i        (vld),
    .byte_i            (bdat),
    .cfg_pan_id_i      (c_pan),
    .cfg_short_addr_i  (c_short),
    .cfg_ext_addr_i    (c_ext),
    .cfg_pan_coord_i   (c_coord),
    .cfg_rsvd_as_data_i(c_rsvd),
    .match_o           (match),
    .reject_o          (reject),
    .ack_req_o         (ackr)
  );

  function automatic bq_t mk(logic [2:0] t, logic ar, logic comp, logic [1:0] ver,
                             logic [1:0] dm, logic [1:0] sm, logic [15:0] dpan,
                             logic [63:0] dadr, logic [15:0] span, logic [63:0] sadr,
                             int npay);
    bq_t q;
    logic [15:0] fc;
    fc = {sm, ver, dm, 2'b00, 1'b0, comp, ar, 2'b00, t};
    q.push_back(fc[7:0]);
    q.push_back(fc[15:8]);
    q.push_back(8'h5A);
    if (dm >= 2) begin
      for (int j = 0; j < 2; j++) q.push_back(dpan[8*j +: 8]);
      for (int j = 0; j < (dm == 3 ? 8 : 2); j++) q.push_back(dadr[8*j +: 8]);
    end
    if (sm >= 2) begin
      if (!comp) for (int j = 0; j < 2; j++) q.push_back(span[8*j +: 8]);
      for (int j = 0; j < (sm == 3 ? 8 : 2); j++) q.push_back(sadr[8*j +: 8]);
    end
    for (int j = 0; j < npay; j++) q.push_back(8'(j * 7 + 1));
    return q;
  endfunction

  // index of the first byte at which the field equals neither allowed value, else -1
  function automatic int fld_chk(bq_t f, int start, int len, logic [63:0] want, logic bc);
    logic ok_w, ok_b;
    ok_w = 1'b1;
    ok_b = bc;
    for (int j = 0; j < len; j++) begin
      ok_w = ok_w && (f[start+j] == want[8*j +: 8]);
      ok_b = ok_b && (f[start+j] == 8'hFF);
      if (!ok_w && !ok_b) return start + j;
    end
    return -1;
  endfunction

  // kind: 0 none, 1 match, 2 reject; at: byte index that settles it
  task automatic model(bq_t f, int cut, output int kind, output int at);
    logic [15:0] fc;
    logic [2:0] t;
    logic comp;
    logic [1:0] dm, sm, ver;
    logic need_src;
    int pos, fail, last, len;
    fc = {f[1], f[0]};
    t = fc[2:0]; comp = fc[6]; dm = fc[11:10]; ver = fc[13:12]; sm = fc[15:14];
    kind = 0; at = -1;
    if (ver >= 2 || t == 2 || (t >= 4 && !c_rsvd) || dm == 1 || sm == 1 ||
        (dm == 0 && sm == 0) || (comp && dm == 0) || (dm == 0 && t != 0 && !c_coord)) begin
      kind = 2; at = 1;
    end else begin
      need_src = (t == 0 && c_pan != 16'hFFFF) || (dm == 0 && t != 0);
      pos = 3; fail = -1; last = 1;
      if (dm != 0) begin
        fail = fld_chk(f, pos, 2, {48'b0, c_pan}, !(need_src && comp));
        pos += 2;
        len = (dm == 3) ? 8 : 2;
        if (fail < 0)
          fail = fld_chk(f, pos, len, (dm == 3) ? c_ext : {48'b0, c_short}, dm == 2);
        pos += len;
        last = pos - 1;
      end
      if (fail < 0 && need_src && !comp) begin
        fail = fld_chk(f, pos, 2, {48'b0, c_pan}, 1'b0);
        last = pos + 1;
      end
      if (fail >= 0) begin kind = 2; at = fail; end
      else begin kind = 1; at = last; end
    end
    if (at >= cut) kind = 0;
  endtask

  task automatic check(logic em, logic er, logic ea, string req);
    n_tests++;
    if (match !== em || reject !== er || ackr !== ea) begin
      n_fail++;
      $display("FAIL %s: match/reject/ack actual %b%b%b expected %b%b%b",
               req, match, reject, ackr, em, er, ea);
    end
  endtask

  // drive on falling edges, compare on every falling edge
  task automatic run(bq_t f, int cut, int gap, string req);
    int kind, at;
    model(f, cut, kind, at);
    for (int i = 0; i < cut; i++) begin
      vld = 1'b1; sof = (i == 0); bdat = f[i];
      if (i == 0) cur_ack = f[0][5];
      @(negedge clk);
      vld = 1'b0; sof = 1'b0; bdat = 8'hA5;
      check(kind == 1 && at == i, kind == 2 && at == i, cur_ack, req);
      if (gap > 0 && (i % gap) == gap - 1) begin
        @(negedge clk);
        check(1'b0, 1'b0, cur_ack, "R11");
      end
    end
    @(negedge clk);
    check(1'b0, 1'b0, cur_ack, "R12");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bq_t f;
    repeat (3) @(negedge clk);
    check(1'b0, 1'b0, 1'b0, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, 1'b0, 1'b0, "R12 reset");

    // R8 R7: data, short dst matches, compressed src, ack requested
    run(mk(3'd1, 1, 1, 2'd1, 2'd2, 2'd2, 16'h1A2B, 64'h0C0D, 16'h0, 64'h3344, 3), 12, 0, "R8");
    // R7 R8: broadcast PAN and short address
    run(mk(3'd1, 0, 1, 2'd0, 2'd2, 2'd2, 16'hFFFF, 64'hFFFF, 16'h0, 64'h3344, 2), 11, 0, "R7");
    // R7: PAN wrong in first byte, then in second byte
    run(mk(3'd1, 1, 0, 2'd0, 2'd2, 2'd0, 16'h1A2C, 64'h0C0D, 16'h0, 64'h0, 2), 9, 0, "R7");
    run(mk(3'd1, 0, 0, 2'd0, 2'd2, 2'd0, 16'h1B2B, 64'h0C0D, 16'h0, 64'h0, 2), 9, 0, "R7");
    // R8: short address mixed FF/config bytes must not pass
    run(mk(3'd1, 0, 0, 2'd0, 2'd2, 2'd0, 16'h1A2B, 64'h0CFF, 16'h0, 64'h0, 1), 8, 0, "R8");
    // R8: extended match, gaps between bytes (R11)
    run(mk(3'd3, 0, 1, 2'd1, 2'd3, 2'd3, 16'h1A2B, 64'h0123_4567_89AB_CDEF, 16'h0,
           64'h1, 1), 22, 3, "R8");
    // R8: extended mismatch in fourth address byte
    run(mk(3'd1, 0, 0, 2'd0, 2'd3, 2'd0, 16'h1A2B, 64'h0123_4567_00AB_CDEF, 16'h0,
           64'h0, 1), 14, 0, "R8");
    // R8: broadcast not allowed for extended destination
    run(mk(3'd1, 0, 0, 2'd0, 2'd3, 2'd0, 16'h1A2B, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0,
           64'h0, 1), 14, 0, "R8");
    // R2: acknowledgement frame
    run(mk(3'd2, 1, 0, 2'd0, 2'd0, 2'd0, 16'h0, 64'h0, 16'h0, 64'h0, 3), 6, 0, "R2");
    // R3: reserved type with policy off, then on
    run(mk(3'd5, 0, 1, 2'd0, 2'd2, 2'd2, 16'h1A2B, 64'h0C0D, 16'h0, 64'h7, 0), 9, 0, "R3");
    c_rsvd = 1'b1;
    run(mk(3'd5, 0, 1, 2'd0, 2'd2, 2'd2, 16'h1A2B, 64'h0C0D, 16'h0, 64'h7, 0), 9, 0, "R3");
    run(mk(3'd7, 0, 1, 2'd0, 2'd2, 2'd2, 16'h1A2B, 64'h0C0E, 16'h0, 64'h7, 0), 9, 0, "R3");
    c_rsvd = 1'b0;
    // R4: versions 2 and 3 rejected
    run(mk(3'd1, 0, 1, 2'd2, 2'd2, 2'd2, 16'h1A2B, 64'h0C0D, 16'h0, 64'h7, 0), 9, 0, "R4");
    run(mk(3'd3, 0, 1, 2'd3, 2'd2, 2'd2, 16'h1A2B, 64'h0C0D, 16'h0, 64'h7, 0), 9, 0, "R4");
    // R5: reserved mode, no addresses, compression without destination
    run(mk(3'd1, 0, 0, 2'd0, 2'd1, 2'd2, 16'h0, 64'h0, 16'h1A2B, 64'h7, 4), 8, 0, "R5");
    run(mk(3'd1, 0, 0, 2'd0, 2'd0, 2'd0, 16'h0, 64'h0, 16'h0, 64'h0, 4), 7, 0, "R5");
    c_coord = 1'b1;
    run(mk(3'd1, 0, 1, 2'd0, 2'd0, 2'd2, 16'h0, 64'h0, 16'h0, 64'h7, 2), 7, 0, "R5");
    // R10: only source addressing, coordinator, source PAN right and wrong
    run(mk(3'd1, 0, 0, 2'd0, 2'd0, 2'd2, 16'h0, 64'h0, 16'h1A2B, 64'h7, 2), 9, 0, "R10");
    run(mk(3'd3, 0, 0, 2'd0, 2'd0, 2'd3, 16'h0, 64'h0, 16'hFFFF, 64'h7, 2), 15, 0, "R10");
    c_coord = 1'b0;
    run(mk(3'd1, 0, 0, 2'd0, 2'd0, 2'd2, 16'h0, 64'h0, 16'h1A2B, 64'h7, 2), 9, 0, "R10");
    // R9: beacon, source PAN right, wrong
    run(mk(3'd0, 0, 0, 2'd0, 2'd0, 2'd2, 16'h0, 64'h0, 16'h1A2B, 64'h7, 2), 9, 0, "R9");
    run(mk(3'd0, 0, 0, 2'd0, 2'd0, 2'd2, 16'h0, 64'h0, 16'h1A00, 64'h7, 2), 9, 0, "R9");
    // R9: beacon with compression: destination PAN broadcast not enough
    run(mk(3'd0, 0, 1, 2'd0, 2'd2, 2'd2, 16'hFFFF, 64'h0C0D, 16'h0, 64'h7, 1), 10, 0, "R9");
    // R9: beacon with destination, uncompressed: decided at source PAN
    run(mk(3'd0, 0, 0, 2'd1, 2'd2, 2'd2, 16'hFFFF, 64'hFFFF, 16'h1A2B, 64'h7, 1), 12, 0, "R9");
    // R9: configured PAN all ones accepts any beacon at second byte
    c_pan = 16'hFFFF;
    run(mk(3'd0, 1, 0, 2'd0, 2'd0, 2'd2, 16'h0, 64'h0, 16'h1234, 64'h7, 2), 9, 0, "R9");
    c_pan = 16'h1A2B;
    // R6: data with destination and wrong uncompressed source PAN still matches
    run(mk(3'd1, 1, 0, 2'd0, 2'd2, 2'd2, 16'h1A2B, 64'h0C0D, 16'h9999, 64'h7, 3), 14, 0, "R6");
    // R12: frame cut short by a new start, then a full frame; R11 gaps
    f = mk(3'd1, 1, 0, 2'd0, 2'd3, 2'd0, 16'h1A2B, 64'h0123_4567_89AB_CDEF, 16'h0, 64'h0, 0);
    run(f, 6, 0, "R12");
    run(mk(3'd1, 0, 1, 2'd0, 2'd2, 2'd2, 16'h1A2B, 64'h0C0D, 16'h0, 64'h3344, 4), 13, 2, "R11");
    // R1: ack request bit both values
    run(mk(3'd2, 1, 0, 2'd0, 2'd0, 2'd0, 16'h0, 64'h0, 16'h0, 64'h0, 1), 4, 0, "R1");
    run(mk(3'd2, 0, 0, 2'd0, 2'd0, 2'd0, 16'h0, 64'h0, 16'h0, 64'h0, 1), 4, 0, "R1");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule